// File: doc/BRIEF.md
# RV64IM Operation Decoder

This block turns one 32-bit RV64IM instruction word, together with its program counter, into a flat control record for a downstream table-driven datapath. The record has three parts. The first is a one-hot operation selector covering sixteen operation classes. The second is a set of modifier bits that tell related instructions apart when they share a class. The third holds three 8-bit register indices with their enables, a 64-bit sign-extended immediate, the program counter and an illegal-instruction bit. Related instructions are folded onto one class and told apart only by the modifier bits. Examples are set-less-than against its unsigned form, the three shifts, the four multiplies, and branch-equal against branch-not-equal. AUIPC and JAL read a virtual register numbered 255 in place of a source register. The system call always names the same three ABI registers.

The result is held in a single output register with a valid/ready handshake on both sides. Two auxiliary modes ignore the instruction word and emit fixed rows used to fill a table to its required length. A pad row carries program counter 7 and only the breakpoint class. A filler row carries program counter 1 and nothing else. Compressed instructions are not decoded.

Top module: `rv_op_decoder`

## Requirements
- R1: `out_ops` is one-hot on every legal decode, with bit positions ADD=0, SUB=1, SLT=2, AND=3, OR=4, XOR=5, SHIFT=6, MUL=7, DIVREM=8, JALR=9, BEQ=10, BLT=11, LOAD=12, STORE=13, ECALL=14, EBREAK=15. Any modifier bit an instruction does not call for is 0. `out_mods` bits are: word=0, signed=1, mp=2, muldiv=3, size8=4, size4=5, size2=6.
- R2: Fields an instruction does not use read as 0. `out_rs1_en`, `out_rs2_en` and `out_rd_en` are 1 exactly when the matching index is nonzero.
- R3: The word bit is 1 for ADDIW, SLLIW, SRLIW, SRAIW, ADDW, SUBW, SLLW, SRLW, SRAW, MULW, DIVW, DIVUW, REMW and REMUW, and 0 for every other instruction.
- R4: SLL/SLLI decode as SHIFT alone. SRL/SRLI add mp. SRA/SRAI add mp and signed. SLT/SLTI set signed and their unsigned forms do not.
- R5: MUL/MULW decode as MUL with signed+mp. MULH adds muldiv to that. MULHSU is signed+muldiv and MULHU is muldiv only. DIV/DIVU decode as DIVREM. REM/REMU add muldiv. The signed forms set signed.
- R6: BEQ decodes as BEQ and BNE as BEQ+mp. BLT/BLTU decode as BLT and BGE/BGEU as BLT+mp. The signed forms set signed.
- R7: LUI and FENCE decode as ADD. FENCE has all registers and the immediate at 0. AUIPC decodes as ADD with rs1=255. JAL decodes as JALR with rs1=255.
- R8: Immediates are sign-extended to 64 bits from the I, S, B, U and J formats, and B and J carry bit 0 = 0. Shift-by-immediate forms give the shift amount zero-extended: 6 bits for the 64-bit forms and 5 bits for the word forms.
- R9: Loads set LOAD and stores set STORE. Doubleword sets size8, word sets size4, halfword sets size2 and byte sets none. LB/LH/LW set signed and LD, LBU, LHU and LWU do not.
- R10: ECALL (0x00000073) gives ECALL with rs1=17, rs2=10 and rd=10. EBREAK (0x00100073) gives only the EBREAK bit.
- R11: `in_mode` selects the row. Mode 0 or 3 decodes normally and passes `in_pc` through. Mode 1 emits pc=7 with only ops bit 15 set. Mode 2 emits pc=1 with every other field 0. Modes 1 and 2 ignore the instruction word.
- R12: A transfer takes place when `in_valid` and `in_ready` are both high. The record appears on the outputs in the next cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold. Reset clears `out_valid`.
- R13: An unknown opcode or an unknown funct combination raises `out_illegal`. In that case ops, mods, indices, enables and the immediate are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 64 | Program counter of the instruction |
| in_mode | input | 2 | 0/3 decode, 1 pad row, 2 filler row |
| out_valid | output | 1 | Output record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_ops | output | 16 | One-hot operation class |
| out_mods | output | 7 | Modifier bits |
| out_rs1 | output | 8 | First source index |
| out_rs2 | output | 8 | Second source index |
| out_rd | output | 8 | Destination index |
| out_rs1_en | output | 1 | rs1 nonzero |
| out_rs2_en | output | 1 | rs2 nonzero |
| out_rd_en | output | 1 | rd nonzero |
| out_imm | output | 64 | Sign-extended immediate |
| out_pc | output | 64 | Program counter of the row |
| out_illegal | output | 1 | Instruction not recognised |

## Verification
The bench sweeps every supported mnemonic with all-zero, all-ones and pseudo-random register and immediate fields. A decoder with a sliced immediate bit in the B or J format, a swapped fold between mp and muldiv, or a stale register enable would produce a wrong field there. Every major opcode value outside the legal set is tried, as are the neighbouring funct encodings: SLLI with bit 26 set, SRAIW with bit 25 set, a high multiply in the word opcode, and branch, load and store funct3 gaps. A decoder that is too permissive would leave a class bit set or fail to raise illegal. The pad and filler rows are driven with a live instruction on the input, so a leak of decoded fields shows up. A stalled consumer shows whether the output register holds its record and refuses new input.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int XLEN  = 64;
  localparam int ILEN  = 32;
  localparam int REGW  = 8;
  localparam int NOPS  = 16;
  localparam int NMODS = 7;
  localparam int OPW   = $clog2(NOPS);

  // operation class positions in the one-hot selector
  localparam int OP_ADD = 0,  OP_SUB = 1,  OP_SLT = 2,  OP_AND = 3;
  localparam int OP_OR  = 4,  OP_XOR = 5,  OP_SHIFT = 6, OP_MUL = 7;
  localparam int OP_DIVREM = 8, OP_JALR = 9, OP_BEQ = 10, OP_BLT = 11;
  localparam int OP_LOAD = 12, OP_STORE = 13, OP_ECALL = 14, OP_EBREAK = 15;

  // modifier bit positions
  localparam int M_WORD = 0, M_SGN = 1, M_MP = 2, M_MD = 3;
  localparam int M_SZ8 = 4, M_SZ4 = 5, M_SZ2 = 6;

  typedef enum logic [3:0] {
    FMT_NONE, FMT_R, FMT_I, FMT_SH6, FMT_SH5, FMT_S, FMT_B, FMT_U, FMT_J
  } fmt_e;

  typedef enum logic [1:0] {
    MODE_DEC = 2'd0, MODE_PAD = 2'd1, MODE_FILL = 2'd2, MODE_DEC2 = 2'd3
  } mode_e;

  typedef struct packed {
    logic [NOPS-1:0]  ops;
    logic [NMODS-1:0] mods;
    logic [REGW-1:0]  rs1;
    logic [REGW-1:0]  rs2;
    logic [REGW-1:0]  rd;
    logic             rs1_en;
    logic             rs2_en;
    logic             rd_en;
    logic [XLEN-1:0]  imm;
    logic [XLEN-1:0]  pc;
    logic             illegal;
  } dec_rec_t;
endpackage

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
  import rvdec_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int XW = XLEN
) (
  input  logic [IW-1:0] instr,
  input  fmt_e          fmt,
  output logic [XW-1:0] imm
);
  localparam int SH6W = 6;
  localparam int SH5W = 5;
  logic s;
  assign s = instr[IW-1];

  always_comb begin
    imm = '0;
    unique case (fmt)
      FMT_I:   imm = {{(XW-12){s}}, instr[31:20]};
      FMT_SH6: imm = {{(XW-SH6W){1'b0}}, instr[25:20]};
      FMT_SH5: imm = {{(XW-SH5W){1'b0}}, instr[24:20]};
      FMT_S:   imm = {{(XW-12){s}}, instr[31:25], instr[11:7]};
      FMT_B:   imm = {{(XW-12){s}}, instr[7], instr[30:25], instr[11:8], 1'b0};
      FMT_U:   imm = {{(XW-32){s}}, instr[31:12], 12'b0};
      FMT_J:   imm = {{(XW-20){s}}, instr[19:12], instr[20], instr[30:21], 1'b0};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
#(
  parameter int          IW   = ILEN,
  parameter int          RW   = REGW,
  parameter logic [RW-1:0] VREG = '1
) (
  input  logic [IW-1:0]    instr,
  output logic [NOPS-1:0]  ops,
  output logic [NMODS-1:0] mods,
  output logic [RW-1:0]    rs1,
  output logic [RW-1:0]    rs2,
  output logic [RW-1:0]    rd,
  output fmt_e             fmt,
  output logic             illegal
);
  localparam logic [IW-1:0] ENC_ECALL  = 32'h0000_0073;
  localparam logic [IW-1:0] ENC_EBREAK = 32'h0010_0073;
  localparam logic [RW-1:0] ABI_A7 = RW'(17);
  localparam logic [RW-1:0] ABI_A0 = RW'(10);

  logic [6:0]     opc;
  logic [2:0]     f3;
  logic [6:0]     f7;
  logic [RW-1:0]  f_rd, f_rs1, f_rs2;
  logic [OPW-1:0] op;
  logic           hit, use_v, is_ecall;
  fmt_e           fsel;
  logic [NMODS-1:0] m;

  assign opc   = instr[6:0];
  assign f3    = instr[14:12];
  assign f7    = instr[31:25];
  assign f_rd  = RW'(instr[11:7]);
  assign f_rs1 = RW'(instr[19:15]);
  assign f_rs2 = RW'(instr[24:20]);

  always_comb begin
    op = OPW'(OP_ADD); hit = 1'b0; use_v = 1'b0; is_ecall = 1'b0;
    fsel = FMT_NONE; m = '0;
    unique case (opc)
      7'h13: begin
        hit = 1'b1; fsel = FMT_I;
        unique case (f3)
          3'd0: op = OPW'(OP_ADD);
          3'd2: begin op = OPW'(OP_SLT); m[M_SGN] = 1'b1; end
          3'd3: op = OPW'(OP_SLT);
          3'd4: op = OPW'(OP_XOR);
          3'd6: op = OPW'(OP_OR);
          3'd7: op = OPW'(OP_AND);
          3'd1: begin op = OPW'(OP_SHIFT); fsel = FMT_SH6; hit = (instr[31:26] == 6'h00); end
          default: begin
            op = OPW'(OP_SHIFT); fsel = FMT_SH6; m[M_MP] = 1'b1;
            if (instr[31:26] == 6'h10) m[M_SGN] = 1'b1;
            else if (instr[31:26] != 6'h00) hit = 1'b0;
          end
        endcase
      end
      7'h1B: begin
        hit = 1'b1; m[M_WORD] = 1'b1;
        unique case (f3)
          3'd0: begin op = OPW'(OP_ADD); fsel = FMT_I; end
          3'd1: begin op = OPW'(OP_SHIFT); fsel = FMT_SH5; hit = (f7 == 7'h00); end
          3'd5: begin
            op = OPW'(OP_SHIFT); fsel = FMT_SH5; m[M_MP] = 1'b1;
            if (f7 == 7'h20) m[M_SGN] = 1'b1;
            else if (f7 != 7'h00) hit = 1'b0;
          end
          default: hit = 1'b0;
        endcase
      end
      7'h33, 7'h3B: begin
        hit = 1'b1; fsel = FMT_R; m[M_WORD] = opc[3];
        if (f7 == 7'h01) begin
          unique case (f3)
            3'd0: begin op = OPW'(OP_MUL); m[M_SGN] = 1'b1; m[M_MP] = 1'b1; end
            3'd1: begin op = OPW'(OP_MUL); m[M_SGN] = 1'b1; m[M_MP] = 1'b1; m[M_MD] = 1'b1; end
            3'd2: begin op = OPW'(OP_MUL); m[M_SGN] = 1'b1; m[M_MD] = 1'b1; end
            3'd3: begin op = OPW'(OP_MUL); m[M_MD] = 1'b1; end
            3'd4: begin op = OPW'(OP_DIVREM); m[M_SGN] = 1'b1; end
            3'd5: op = OPW'(OP_DIVREM);
            3'd6: begin op = OPW'(OP_DIVREM); m[M_SGN] = 1'b1; m[M_MD] = 1'b1; end
            default: begin op = OPW'(OP_DIVREM); m[M_MD] = 1'b1; end
          endcase
          if (opc[3] && (f3 inside {3'd1, 3'd2, 3'd3})) hit = 1'b0;
        end else if (f7 == 7'h00) begin
          unique case (f3)
            3'd0: op = OPW'(OP_ADD);
            3'd1: op = OPW'(OP_SHIFT);
            3'd2: begin op = OPW'(OP_SLT); m[M_SGN] = 1'b1; end
            3'd3: op = OPW'(OP_SLT);
            3'd4: op = OPW'(OP_XOR);
            3'd5: begin op = OPW'(OP_SHIFT); m[M_MP] = 1'b1; end
            3'd6: op = OPW'(OP_OR);
            default: op = OPW'(OP_AND);
          endcase
          if (opc[3] && !(f3 inside {3'd0, 3'd1, 3'd5})) hit = 1'b0;
        end else if (f7 == 7'h20 && f3 == 3'd0) begin
          op = OPW'(OP_SUB);
        end else if (f7 == 7'h20 && f3 == 3'd5) begin
          op = OPW'(OP_SHIFT); m[M_MP] = 1'b1; m[M_SGN] = 1'b1;
        end else begin
          hit = 1'b0;
        end
      end
      7'h37: begin hit = 1'b1; fsel = FMT_U; op = OPW'(OP_ADD); end
      7'h17: begin hit = 1'b1; fsel = FMT_U; op = OPW'(OP_ADD); use_v = 1'b1; end
      7'h6F: begin hit = 1'b1; fsel = FMT_J; op = OPW'(OP_JALR); use_v = 1'b1; end
      7'h67: begin hit = (f3 == 3'd0); fsel = FMT_I; op = OPW'(OP_JALR); end
      7'h63: begin
        hit = 1'b1; fsel = FMT_B;
        op = f3[2] ? OPW'(OP_BLT) : OPW'(OP_BEQ);
        m[M_MP]  = f3[0];
        m[M_SGN] = f3[2] & ~f3[1];
        if (f3 == 3'd2 || f3 == 3'd3) hit = 1'b0;
      end
      7'h03: begin
        hit = (f3 != 3'd7); fsel = FMT_I; op = OPW'(OP_LOAD);
        m[M_SGN] = ~f3[2] & (f3[1:0] != 2'd3);
        m[M_SZ8] = (f3[1:0] == 2'd3);
        m[M_SZ4] = (f3[1:0] == 2'd2);
        m[M_SZ2] = (f3[1:0] == 2'd1);
      end
      7'h23: begin
        hit = ~f3[2]; fsel = FMT_S; op = OPW'(OP_STORE);
        m[M_SZ8] = (f3[1:0] == 2'd3);
        m[M_SZ4] = (f3[1:0] == 2'd2);
        m[M_SZ2] = (f3[1:0] == 2'd1);
      end
      7'h73: begin
        if (instr == ENC_ECALL) begin hit = 1'b1; op = OPW'(OP_ECALL); is_ecall = 1'b1; end
        else if (instr == ENC_EBREAK) begin hit = 1'b1; op = OPW'(OP_EBREAK); end
      end
      7'h0F: begin hit = (f3 == 3'd0); op = OPW'(OP_ADD); end
      default: hit = 1'b0;
    endcase
  end

  // operand routing by format, then the rewrite cases
  always_comb begin
    rs1 = '0; rs2 = '0; rd = '0;
    if (hit) begin
      unique case (fsel)
        FMT_R:                 begin rd = f_rd; rs1 = f_rs1; rs2 = f_rs2; end
        FMT_I, FMT_SH6, FMT_SH5: begin rd = f_rd; rs1 = f_rs1; end
        FMT_S, FMT_B:          begin rs1 = f_rs1; rs2 = f_rs2; end
        FMT_U, FMT_J:          rd = f_rd;
        default: ;
      endcase
      if (use_v) rs1 = VREG;
      if (is_ecall) begin rs1 = ABI_A7; rs2 = ABI_A0; rd = ABI_A0; end
    end
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_onehot
    assign ops[g] = hit && (op == OPW'(g));
  end

  assign mods    = hit ? m : '0;
  assign fmt     = hit ? fsel : FMT_NONE;
  assign illegal = ~hit;
endmodule

// File: rtl/rvdec_stage.sv
module rvdec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rv_op_decoder.sv
module rv_op_decoder
  import rvdec_pkg::*;
#(
  parameter logic [XLEN-1:0] PAD_PC  = 64'd7,
  parameter logic [XLEN-1:0] FILL_PC = 64'd1,
  parameter logic [REGW-1:0] VREG    = 8'd255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ILEN-1:0]  in_instr,
  input  logic [XLEN-1:0]  in_pc,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NOPS-1:0]  out_ops,
  output logic [NMODS-1:0] out_mods,
  output logic [REGW-1:0]  out_rs1,
  output logic [REGW-1:0]  out_rs2,
  output logic [REGW-1:0]  out_rd,
  output logic             out_rs1_en,
  output logic             out_rs2_en,
  output logic             out_rd_en,
  output logic [XLEN-1:0]  out_imm,
  output logic [XLEN-1:0]  out_pc,
  output logic             out_illegal
);
  localparam int RECW = $bits(dec_rec_t);

  logic [NOPS-1:0]  d_ops;
  logic [NMODS-1:0] d_mods;
  logic [REGW-1:0]  d_rs1, d_rs2, d_rd;
  logic [XLEN-1:0]  d_imm;
  logic             d_ill;
  fmt_e             d_fmt;
  dec_rec_t         rec_n, rec_q;
  logic [RECW-1:0]  q_bits;

  rvdec_ctrl #(.IW(ILEN), .RW(REGW), .VREG(VREG)) i_ctrl (
    .instr(in_instr), .ops(d_ops), .mods(d_mods),
    .rs1(d_rs1), .rs2(d_rs2), .rd(d_rd), .fmt(d_fmt), .illegal(d_ill)
  );

  rvdec_immgen #(.IW(ILEN), .XW(XLEN)) i_imm (
    .instr(in_instr), .fmt(d_fmt), .imm(d_imm)
  );

  always_comb begin
    rec_n = '0;
    unique case (mode_e'(in_mode))
      MODE_PAD: begin
        rec_n.pc = PAD_PC;
        rec_n.ops[OP_EBREAK] = 1'b1;
      end
      MODE_FILL: rec_n.pc = FILL_PC;
      default: begin
        rec_n.ops     = d_ops;
        rec_n.mods    = d_mods;
        rec_n.rs1     = d_rs1;
        rec_n.rs2     = d_rs2;
        rec_n.rd      = d_rd;
        rec_n.rs1_en  = |d_rs1;
        rec_n.rs2_en  = |d_rs2;
        rec_n.rd_en   = |d_rd;
        rec_n.imm     = d_imm;
        rec_n.pc      = in_pc;
        rec_n.illegal = d_ill;
      end
    endcase
  end

  rvdec_stage #(.W(RECW)) i_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(rec_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(q_bits)
  );

  assign rec_q       = dec_rec_t'(q_bits);
  assign out_ops     = rec_q.ops;
  assign out_mods    = rec_q.mods;
  assign out_rs1     = rec_q.rs1;
  assign out_rs2     = rec_q.rs2;
  assign out_rd      = rec_q.rd;
  assign out_rs1_en  = rec_q.rs1_en;
  assign out_rs2_en  = rec_q.rs2_en;
  assign out_rd_en   = rec_q.rd_en;
  assign out_imm     = rec_q.imm;
  assign out_pc      = rec_q.pc;
  assign out_illegal = rec_q.illegal;
endmodule

// File: rtl/rvdec_checker.sv
module rvdec_checker
  import rvdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NOPS-1:0]  out_ops,
  input logic [NMODS-1:0] out_mods,
  input logic [REGW-1:0]  out_rs1,
  input logic [REGW-1:0]  out_rs2,
  input logic [REGW-1:0]  out_rd,
  input logic             out_rs1_en,
  input logic             out_rs2_en,
  input logic             out_rd_en,
  input logic [XLEN-1:0]  out_imm,
  input logic             out_illegal
);
  // R1: never more than one class
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_ops));

  // R2: enables track nonzero indices
  p_enables_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rs1_en == (out_rs1 != '0)) && (out_rs2_en == (out_rs2 != '0))
                  && (out_rd_en == (out_rd != '0)));

  // R9: at most one access size
  p_size_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_mods[M_SZ2:M_SZ8]) <= 1);

  // R6: branch offsets are even
  p_branch_even_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_ops[OP_BEQ] || out_ops[OP_BLT]) |-> !out_imm[0]);

  // R13: an illegal row carries nothing
  p_illegal_zero_r13: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_ops == '0 && out_mods == '0 && out_imm == '0
                                 && out_rs1 == '0 && out_rs2 == '0 && out_rd == '0);

  // R12: stalled record holds and input is refused
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ops) && $stable(out_imm)
                                && $stable(out_rd));
  p_refuse_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  p_accept_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
endmodule

bind rv_op_decoder rvdec_checker i_rvdec_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ops(out_ops),
  .out_mods(out_mods), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
  .out_rs1_en(out_rs1_en), .out_rs2_en(out_rs2_en), .out_rd_en(out_rd_en),
  .out_imm(out_imm), .out_illegal(out_illegal)
);

// File: tb/test_rv_op_decoder.sv
`timescale 1ns/1ps
module test_rv_op_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [63:0] in_pc = '0;
  logic [1:0]  in_mode = 2'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ops;
  logic [6:0]  out_mods;
  logic [7:0]  out_rs1, out_rs2, out_rd;
  logic        out_rs1_en, out_rs2_en, out_rd_en;
  logic [63:0] out_imm, out_pc;
  logic        out_illegal;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  rv_op_decoder i_rv_op_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_ops(out_ops),
    .out_mods(out_mods), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
    .out_rs1_en(out_rs1_en), .out_rs2_en(out_rs2_en), .out_rd_en(out_rd_en),
    .out_imm(out_imm), .out_pc(out_pc), .out_illegal(out_illegal)
  );

  // format codes: 0 R, 1 I, 2 shift6, 3 shift5, 4 S, 5 B, 6 U, 7 J
  typedef struct {
    logic [6:0] opc; logic [2:0] f3; logic [6:0] f7;
    int fmt; int op; logic [6:0] mods; int req; bit vreg;
  } kind_t;

  localparam logic [6:0] W = 7'h01, S = 7'h02, MP = 7'h04, MD = 7'h08;
  localparam logic [6:0] B8 = 7'h10, B4 = 7'h20, B2 = 7'h40;
  localparam int NKIND = 62;

  function automatic kind_t mk(logic [6:0] o, logic [2:0] f3, logic [6:0] f7,
                               int fmt, int op, logic [6:0] m, int req, bit v);
    kind_t k;
    k.opc = o; k.f3 = f3; k.f7 = f7; k.fmt = fmt; k.op = op; k.mods = m; k.req = req; k.vreg = v;
    return k;
  endfunction

  // req tags: R1 base, R3 word, R4 shift/slt, R5 muldiv, R6 branch, R7 rewrites, R9 memory
  function automatic kind_t kind(int i);
    case (i)
      0:  return mk(7'h13,0,0,1,0,0,1,0);       1:  return mk(7'h13,2,0,1,2,S,4,0);
      2:  return mk(7'h13,3,0,1,2,0,4,0);       3:  return mk(7'h13,4,0,1,5,0,1,0);
      4:  return mk(7'h13,6,0,1,4,0,1,0);       5:  return mk(7'h13,7,0,1,3,0,1,0);
      6:  return mk(7'h13,1,7'h00,2,6,0,4,0);   7:  return mk(7'h13,5,7'h00,2,6,MP,4,0);
      8:  return mk(7'h13,5,7'h20,2,6,MP|S,4,0);
      9:  return mk(7'h1B,0,0,1,0,W,3,0);       10: return mk(7'h1B,1,7'h00,3,6,W,3,0);
      11: return mk(7'h1B,5,7'h00,3,6,W|MP,3,0);12: return mk(7'h1B,5,7'h20,3,6,W|MP|S,3,0);
      13: return mk(7'h33,0,7'h00,0,0,0,1,0);   14: return mk(7'h33,0,7'h20,0,1,0,1,0);
      15: return mk(7'h33,1,7'h00,0,6,0,4,0);   16: return mk(7'h33,2,7'h00,0,2,S,4,0);
      17: return mk(7'h33,3,7'h00,0,2,0,4,0);   18: return mk(7'h33,4,7'h00,0,5,0,1,0);
      19: return mk(7'h33,5,7'h00,0,6,MP,4,0);  20: return mk(7'h33,5,7'h20,0,6,MP|S,4,0);
      21: return mk(7'h33,6,7'h00,0,4,0,1,0);   22: return mk(7'h33,7,7'h00,0,3,0,1,0);
      23: return mk(7'h33,0,7'h01,0,7,S|MP,5,0);24: return mk(7'h33,1,7'h01,0,7,S|MP|MD,5,0);
      25: return mk(7'h33,2,7'h01,0,7,S|MD,5,0);26: return mk(7'h33,3,7'h01,0,7,MD,5,0);
      27: return mk(7'h33,4,7'h01,0,8,S,5,0);   28: return mk(7'h33,5,7'h01,0,8,0,5,0);
      29: return mk(7'h33,6,7'h01,0,8,S|MD,5,0);30: return mk(7'h33,7,7'h01,0,8,MD,5,0);
      31: return mk(7'h3B,0,7'h00,0,0,W,3,0);   32: return mk(7'h3B,0,7'h20,0,1,W,3,0);
      33: return mk(7'h3B,1,7'h00,0,6,W,3,0);   34: return mk(7'h3B,5,7'h00,0,6,W|MP,3,0);
      35: return mk(7'h3B,5,7'h20,0,6,W|MP|S,3,0);
      36: return mk(7'h3B,0,7'h01,0,7,W|S|MP,3,0);
      37: return mk(7'h3B,4,7'h01,0,8,W|S,3,0); 38: return mk(7'h3B,5,7'h01,0,8,W,3,0);
      39: return mk(7'h3B,6,7'h01,0,8,W|S|MD,3,0);
      40: return mk(7'h3B,7,7'h01,0,8,W|MD,3,0);
      41: return mk(7'h37,0,0,6,0,0,7,0);       42: return mk(7'h17,0,0,6,0,0,7,1);
      43: return mk(7'h6F,0,0,7,9,0,7,1);       44: return mk(7'h67,0,0,1,9,0,1,0);
      45: return mk(7'h63,0,0,5,10,0,6,0);      46: return mk(7'h63,1,0,5,10,MP,6,0);
      47: return mk(7'h63,4,0,5,11,S,6,0);      48: return mk(7'h63,5,0,5,11,S|MP,6,0);
      49: return mk(7'h63,6,0,5,11,0,6,0);      50: return mk(7'h63,7,0,5,11,MP,6,0);
      51: return mk(7'h03,0,0,1,12,S,9,0);      52: return mk(7'h03,1,0,1,12,S|B2,9,0);
      53: return mk(7'h03,2,0,1,12,S|B4,9,0);   54: return mk(7'h03,3,0,1,12,B8,9,0);
      55: return mk(7'h03,4,0,1,12,0,9,0);      56: return mk(7'h03,5,0,1,12,B2,9,0);
      57: return mk(7'h03,6,0,1,12,B4,9,0);     58: return mk(7'h23,0,0,4,13,0,9,0);
      59: return mk(7'h23,1,0,4,13,B2,9,0);     60: return mk(7'h23,2,0,4,13,B4,9,0);
      default: return mk(7'h23,3,0,4,13,B8,9,0);
    endcase
  endfunction

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one input, accepted at the next edge; outputs sampled 1 ns after it
  task automatic send(input logic [31:0] ins, input logic [63:0] pc, input logic [1:0] md);
    @(negedge clk);
    in_instr = ins; in_pc = pc; in_mode = md; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_row(input int req, input logic [15:0] ops, input logic [6:0] mods,
                            input logic [7:0] r1, input logic [7:0] r2, input logic [7:0] rd,
                            input logic [63:0] imm, input logic ill);
    chk(out_valid === 1'b1, 12, "valid", 64'(out_valid), 64'd1);
    chk(out_ops === ops, req, "ops", 64'(out_ops), 64'(ops));
    chk(out_mods === mods, req, "mods", 64'(out_mods), 64'(mods));
    chk({out_rs1, out_rs2, out_rd} === {r1, r2, rd}, 2, "regs",
        64'({out_rs1, out_rs2, out_rd}), 64'({r1, r2, rd}));
    chk({out_rs1_en, out_rs2_en, out_rd_en} === {r1 != 0, r2 != 0, rd != 0}, 2, "enables",
        64'({out_rs1_en, out_rs2_en, out_rd_en}), 64'({r1 != 0, r2 != 0, rd != 0}));
    chk(out_imm === imm, 8, "imm", out_imm, imm);
    chk(out_illegal === ill, 13, "illegal", 64'(out_illegal), 64'(ill));
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk(out_valid === 1'b0, 12, "reset valid", 64'(out_valid), 64'd0);
    @(negedge clk) rst = 1'b0;
    #1 chk(in_ready === 1'b1, 12, "reset ready", 64'(in_ready), 64'd1);

    // sweep every table mnemonic (R1, R3, R4, R5, R6, R7, R8, R9)
    for (int k = 0; k < NKIND; k++) begin
      for (int it = 0; it < 8; it++) begin
        kind_t e = kind(k);
        logic [4:0] rd, r1, r2;
        logic [31:0] r, ins;
        logic [12:0] v13;
        logic [20:0] v21;
        logic [63:0] ev, pc;
        logic [7:0] x1, x2, xd;
        seed = nxt(seed); r = seed;
        seed = nxt(seed);
        rd = seed[4:0]; r1 = seed[9:5]; r2 = seed[14:10];
        pc = {seed, r};
        if (it == 0) begin rd = 0; r1 = 0; r2 = 0; r = 0; end
        if (it == 1) begin rd = 31; r1 = 31; r2 = 31; r = '1; end
        v13 = {r[12:1], 1'b0};
        v21 = {r[20:1], 1'b0};
        ev = '0; x1 = 0; x2 = 0; xd = 0;
        case (e.fmt)
          0: begin ins = {e.f7, r2, r1, e.f3, rd, e.opc}; xd = rd; x1 = r1; x2 = r2; end
          1: begin ins = {r[11:0], r1, e.f3, rd, e.opc}; ev = 64'($signed(r[11:0])); xd = rd; x1 = r1; end
          2: begin ins = {e.f7[6:1], r[5:0], r1, e.f3, rd, e.opc}; ev = 64'(r[5:0]); xd = rd; x1 = r1; end
          3: begin ins = {e.f7, r[4:0], r1, e.f3, rd, e.opc}; ev = 64'(r[4:0]); xd = rd; x1 = r1; end
          4: begin ins = {r[11:5], r2, r1, e.f3, r[4:0], e.opc}; ev = 64'($signed(r[11:0])); x1 = r1; x2 = r2; end
          5: begin ins = {v13[12], v13[10:5], r2, r1, e.f3, v13[4:1], v13[11], e.opc};
                   ev = 64'($signed(v13)); x1 = r1; x2 = r2; end
          6: begin ins = {r[31:12], rd, e.opc}; ev = 64'($signed({r[31:12], 12'h000})); xd = rd; end
          default: begin ins = {v21[20], v21[10:1], v21[11], v21[19:12], rd, e.opc};
                   ev = 64'($signed(v21)); xd = rd; end
        endcase
        if (e.vreg) x1 = 8'd255;
        send(ins, pc, (it == 3) ? 2'd3 : 2'd0);
        expect_row(e.req, 16'(1) << e.op, e.mods, x1, x2, xd, ev, 1'b0);
        chk(out_pc === pc, 11, "pc pass", out_pc, pc);
      end
    end

    // R10: system instructions; R7: FENCE ignores its fields
    send(32'h0000_0073, 64'h40, 2'd0);
    expect_row(10, 16'h4000, 7'h00, 8'd17, 8'd10, 8'd10, 64'd0, 1'b0);
    send(32'h0010_0073, 64'h44, 2'd0);
    expect_row(10, 16'h8000, 7'h00, 8'd0, 8'd0, 8'd0, 64'd0, 1'b0);
    send(32'h0ff5_808f, 64'h48, 2'd0);
    expect_row(7, 16'h0001, 7'h00, 8'd0, 8'd0, 8'd0, 64'd0, 1'b0);

    // R13: unknown major opcodes
    for (int o = 0; o < 128; o++) begin
      logic [6:0] oc = 7'(o);
      if (!(oc inside {7'h03, 7'h0F, 7'h13, 7'h17, 7'h1B, 7'h23, 7'h33, 7'h37,
                       7'h3B, 7'h63, 7'h67, 7'h6F, 7'h73})) begin
        send({25'h1a5_c3e1, oc}, 64'h80, 2'd0);
        expect_row(13, 16'h0, 7'h0, 8'd0, 8'd0, 8'd0, 64'd0, 1'b1);
      end
    end

    // R13: unknown funct combinations next to legal ones
    for (int j = 0; j < 10; j++) begin
      logic [31:0] bad;
      case (j)
        0: bad = {7'h20, 5'd1, 5'd2, 3'd1, 5'd3, 7'h33};
        1: bad = {7'h01, 5'd1, 5'd2, 3'd1, 5'd3, 7'h3B};
        2: bad = {7'h00, 5'd1, 5'd2, 3'd2, 5'd3, 7'h63};
        3: bad = {12'h004, 5'd2, 3'd7, 5'd3, 7'h03};
        4: bad = {7'h00, 5'd1, 5'd2, 3'd4, 5'd3, 7'h23};
        5: bad = {6'h01, 6'd3, 5'd1, 3'd1, 5'd2, 7'h13};
        6: bad = {7'h21, 5'd3, 5'd1, 3'd5, 5'd2, 7'h1B};
        7: bad = {12'h010, 5'd1, 3'd1, 5'd2, 7'h67};
        8: bad = 32'h0020_0073;
        default: bad = 32'h0000_100F;
      endcase
      send(bad, 64'h90, 2'd0);
      expect_row(13, 16'h0, 7'h0, 8'd0, 8'd0, 8'd0, 64'd0, 1'b1);
    end

    // R11: pad and filler rows ignore a live instruction
    send({7'h01, 5'd7, 5'd9, 3'd0, 5'd4, 7'h33}, 64'h1000, 2'd1);
    expect_row(11, 16'h8000, 7'h0, 8'd0, 8'd0, 8'd0, 64'd0, 1'b0);
    chk(out_pc === 64'd7, 11, "pad pc", out_pc, 64'd7);
    send(32'hffff_ffef, 64'h2000, 2'd2);
    expect_row(11, 16'h0, 7'h0, 8'd0, 8'd0, 8'd0, 64'd0, 1'b0);
    chk(out_pc === 64'd1, 11, "filler pc", out_pc, 64'd1);

    // R12: backpressure holds the record and refuses input
    send({7'h00, 5'd3, 5'd2, 3'd0, 5'd1, 7'h33}, 64'h300, 2'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_instr = {7'h20, 5'd6, 5'd5, 3'd0, 5'd4, 7'h33}; in_pc = 64'h304; in_valid = 1'b1;
    #1 chk(in_ready === 1'b0, 12, "stall ready", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    chk(out_ops === 16'h0001 && out_rd === 8'd1, 12, "stall hold",
        64'({out_ops, out_rd}), 64'({16'h0001, 8'd1}));
    @(negedge clk);
    out_ready = 1'b1;
    #1 chk(in_ready === 1'b1, 12, "release ready", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(out_ops === 16'h0002 && out_rd === 8'd4 && out_pc === 64'h304, 12, "after release",
        64'({out_ops, out_rd}), 64'({16'h0002, 8'd4}));
    @(posedge clk); #1;
    chk(out_valid === 1'b0, 12, "drain", 64'(out_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule